// File: doc/BRIEF.md
# Per-Component Pixel Range Clipper

This block sits in a video transmit path and confines every colour component of a packed pixel to a programmable window. A pixel carries three components: red or red-difference chroma, green or luma, and blue or blue-difference chroma. Each component has its own lower and upper bound. The bounds live in two packed limit registers inside the block, one holding the three upper bounds and one holding the three lower bounds. A software-side write strobe for each register loads it from a shared data bus.

The bounds that load at reset depend on the colour-space mode. When colour conversion is active, the output is YCbCr and the bounds are the narrow video levels. When conversion is bypassed, the output is RGB and the bounds open to almost the whole code range. A change of mode reloads the matching defaults. A full-range control turns clipping off and lets pixels through untouched.

The output pixel is registered once. The valid flag and both sync flags go through the same single stage, so the sidebands stay aligned with the pixel they describe.

Top module: `pixel_range_clipper`

## Requirements
- R1: While `rst` is high, `pix_o`, `pix_vld_o`, `pix_hs_o` and `pix_vs_o` are 0. While `rst` is high, the limit registers take the defaults for the present level of `csc_bypass_i`. For `csc_bypass_i`=0 these are upper 0xF0EBF0 and lower 0x101010. For `csc_bypass_i`=1 these are upper 0xFEFEFE and lower 0x010101.
- R2: Both limit registers use the same field layout: bits 23:16 are red/Cr, bits 15:8 are green/Y and bits 7:0 are blue/Cb. A write with `lim_max_we_i` or `lim_min_we_i` loads `lim_wdata_i` at the clock edge. The new value shows on `lim_max_o`/`lim_min_o` and applies to pixels sampled from the next edge on.
- R3: When `full_range_i` is 0, each component above its upper bound is replaced by that bound. Each component below its lower bound is replaced by that bound. Any other value passes unchanged. All comparisons are unsigned and each component is handled independently.
- R4: If a lower bound is greater than its upper bound, the upper bound wins, and that component's output equals the upper bound for every input value.
- R5: When `full_range_i` is 1, the pixel passes through unchanged whatever the limits are.
- R6: The latency is exactly one clock. `pix_vld_o`, `pix_hs_o` and `pix_vs_o` equal the inputs sampled at the previous edge. The pixel is registered whatever the state of the valid flag.
- R7: When `csc_bypass_i` differs from its level at the previous edge, the limit registers reload the defaults for the new level. This reload overrides any limit write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| csc_bypass_i | input | 1 | 1 = RGB output (conversion bypassed), 0 = YCbCr output |
| full_range_i | input | 1 | 1 = no clipping |
| lim_max_we_i | input | 1 | Write strobe for the upper-bound register |
| lim_min_we_i | input | 1 | Write strobe for the lower-bound register |
| lim_wdata_i | input | 24 | Limit write data, same layout as the pixel |
| pix_i | input | 24 | Input pixel, R/Cr in 23:16, G/Y in 15:8, B/Cb in 7:0 |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_hs_i | input | 1 | Input horizontal sync |
| pix_vs_i | input | 1 | Input vertical sync |
| pix_o | output | 24 | Clipped pixel, one clock later |
| pix_vld_o | output | 1 | Delayed valid |
| pix_hs_o | output | 1 | Delayed horizontal sync |
| pix_vs_o | output | 1 | Delayed vertical sync |
| lim_max_o | output | 24 | Current upper-bound register |
| lim_min_o | output | 24 | Current lower-bound register |

## Verification
The bench builds the block with its default parameters: 8-bit components, three components, and green/luma in the middle lane. With these values the exact default codes of both colour spaces and the packed field positions are visible at the ports. So are the extreme codes 0x00 and 0xFF, which exercise the unsigned comparisons at both ends. Directed steps cover both reset flavours, inverted windows, a mode toggle that collides with a limit write, and the full-range pass-through. A long stretch of random pixels, writes and mode toggles is then compared on every clock with a behavioural model.

// File: rtl/pxclip_pkg.sv
package pxclip_pkg;

  // Sideband flags travelling alongside a pixel
  typedef struct packed {
    logic vld;
    logic hs;
    logic vs;
  } pxclip_sband_t;

  // Role of a component lane, used to pick its YCbCr defaults
  typedef enum logic {
    LANE_CHROMA = 1'b0,
    LANE_LUMA   = 1'b1
  } pxclip_role_e;

  function automatic pxclip_role_e lane_role(input int idx, input int luma_idx);
    return (idx == luma_idx) ? LANE_LUMA : LANE_CHROMA;
  endfunction

endpackage

// File: rtl/pxclip_limit_regs.sv
module pxclip_limit_regs
  import pxclip_pkg::*;
#(
  parameter int COMP_W   = 8,
  parameter int NUM_COMP = 3,
  parameter int LUMA_IDX = 1,
  parameter logic [COMP_W-1:0] YUV_LUMA_LO = 8'h10,
  parameter logic [COMP_W-1:0] YUV_LUMA_HI = 8'hEB,
  parameter logic [COMP_W-1:0] YUV_CHRM_LO = 8'h10,
  parameter logic [COMP_W-1:0] YUV_CHRM_HI = 8'hF0,
  parameter logic [COMP_W-1:0] RGB_LO      = 8'h01,
  parameter logic [COMP_W-1:0] RGB_HI      = 8'hFE,
  localparam int PIX_W = COMP_W * NUM_COMP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csc_bypass_i,
  input  logic             max_we_i,
  input  logic             min_we_i,
  input  logic [PIX_W-1:0] wdata_i,
  output logic [PIX_W-1:0] max_o,
  output logic [PIX_W-1:0] min_o
);

  logic [PIX_W-1:0] dflt_hi;
  logic [PIX_W-1:0] dflt_lo;
  logic [PIX_W-1:0] hi_q;
  logic [PIX_W-1:0] lo_q;
  logic             mode_q;
  logic             mode_flip;

  // Default bounds per lane, chosen by colour-space mode and lane role
  for (genvar g = 0; g < NUM_COMP; g++) begin : g_dflt
    localparam pxclip_role_e ROLE = lane_role(g, LUMA_IDX);
    localparam logic [COMP_W-1:0] YUV_HI = (ROLE == LANE_LUMA) ? YUV_LUMA_HI : YUV_CHRM_HI;
    localparam logic [COMP_W-1:0] YUV_LO = (ROLE == LANE_LUMA) ? YUV_LUMA_LO : YUV_CHRM_LO;
    always_comb begin
      dflt_hi[g*COMP_W +: COMP_W] = csc_bypass_i ? RGB_HI : YUV_HI;
      dflt_lo[g*COMP_W +: COMP_W] = csc_bypass_i ? RGB_LO : YUV_LO;
    end
  end

  assign mode_flip = (csc_bypass_i != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= csc_bypass_i;
      hi_q   <= dflt_hi;
      lo_q   <= dflt_lo;
    end else begin
      mode_q <= csc_bypass_i;
      if (mode_flip) begin
        hi_q <= dflt_hi;
        lo_q <= dflt_lo;
      end else begin
        if (max_we_i) hi_q <= wdata_i;
        if (min_we_i) lo_q <= wdata_i;
      end
    end
  end

  assign max_o = hi_q;
  assign min_o = lo_q;

  // R1
  reset_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hi_q == $past(dflt_hi)) && (lo_q == $past(dflt_lo)));

  // R7
  mode_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(csc_bypass_i) != $past(csc_bypass_i, 2)))
      |-> (hi_q == $past(dflt_hi)) && (lo_q == $past(dflt_lo)));

  // R2
  write_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(max_we_i) && ($past(csc_bypass_i) == $past(csc_bypass_i, 2)))
      |-> hi_q == $past(wdata_i));

endmodule

// File: rtl/pxclip_lane.sv
module pxclip_lane #(
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic [COMP_W-1:0] lo_i,
  input  logic [COMP_W-1:0] hi_i,
  output logic [COMP_W-1:0] comp_o
);

  logic [COMP_W-1:0] raised;
  logic [COMP_W-1:0] capped;
  logic [COMP_W-1:0] comp_q;

  // Floor first, then ceiling, so the upper bound always has the last word
  always_comb begin
    raised = (comp_i < lo_i) ? lo_i : comp_i;
    capped = (raised > hi_i) ? hi_i : raised;
  end

  always_ff @(posedge clk) begin
    if (rst) comp_q <= '0;
    else     comp_q <= full_i ? comp_i : capped;
  end

  assign comp_o = comp_q;

  // R3
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(full_i)) |-> comp_q <= $past(hi_i));

  // R3
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(full_i) && ($past(lo_i) <= $past(hi_i))) |-> comp_q >= $past(lo_i));

  // R4
  inverted_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(full_i) && ($past(lo_i) > $past(hi_i))) |-> comp_q == $past(hi_i));

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(full_i)) |-> comp_q == $past(comp_i));

endmodule

// File: rtl/pixel_range_clipper.sv
module pixel_range_clipper
  import pxclip_pkg::*;
#(
  parameter int COMP_W   = 8,
  parameter int NUM_COMP = 3,
  parameter int LUMA_IDX = 1,
  localparam int PIX_W = COMP_W * NUM_COMP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csc_bypass_i,
  input  logic             full_range_i,
  input  logic             lim_max_we_i,
  input  logic             lim_min_we_i,
  input  logic [PIX_W-1:0] lim_wdata_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             pix_hs_i,
  input  logic             pix_vs_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_vld_o,
  output logic             pix_hs_o,
  output logic             pix_vs_o,
  output logic [PIX_W-1:0] lim_max_o,
  output logic [PIX_W-1:0] lim_min_o
);

  logic [PIX_W-1:0] hi_w;
  logic [PIX_W-1:0] lo_w;
  pxclip_sband_t    sb_d;
  pxclip_sband_t    sb_q;

  pxclip_limit_regs #(
    .COMP_W   (COMP_W),
    .NUM_COMP (NUM_COMP),
    .LUMA_IDX (LUMA_IDX)
  ) u_limits (
    .clk          (clk),
    .rst          (rst),
    .csc_bypass_i (csc_bypass_i),
    .max_we_i     (lim_max_we_i),
    .min_we_i     (lim_min_we_i),
    .wdata_i      (lim_wdata_i),
    .max_o        (hi_w),
    .min_o        (lo_w)
  );

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_lane
    pxclip_lane #(.COMP_W(COMP_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .full_i (full_range_i),
      .comp_i (pix_i[g*COMP_W +: COMP_W]),
      .lo_i   (lo_w[g*COMP_W +: COMP_W]),
      .hi_i   (hi_w[g*COMP_W +: COMP_W]),
      .comp_o (pix_o[g*COMP_W +: COMP_W])
    );
  end

  assign sb_d = '{vld: pix_vld_i, hs: pix_hs_i, vs: pix_vs_i};

  always_ff @(posedge clk) begin
    if (rst) sb_q <= '0;
    else     sb_q <= sb_d;
  end

  assign pix_vld_o = sb_q.vld;
  assign pix_hs_o  = sb_q.hs;
  assign pix_vs_o  = sb_q.vs;
  assign lim_max_o = hi_w;
  assign lim_min_o = lo_w;

  // R6
  sband_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pix_vld_o == $past(pix_vld_i)) && (pix_hs_o == $past(pix_hs_i))
                    && (pix_vs_o == $past(pix_vs_i)));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (pix_o == '0) && !pix_vld_o && !pix_hs_o && !pix_vs_o);

endmodule

// File: tb/pixel_range_clipper_tb_top.sv
`timescale 1ns/1ps
module pixel_range_clipper_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byp = 1'b0, full = 1'b0, we_max = 1'b0, we_min = 1'b0;
  logic [23:0] wdata = '0, pix = '0;
  logic        vld = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [23:0] pix_o, lim_max_o, lim_min_o;
  logic        vld_o, hs_o, vs_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pixel_range_clipper dut_i (
    .clk(clk), .rst(rst), .csc_bypass_i(byp), .full_range_i(full),
    .lim_max_we_i(we_max), .lim_min_we_i(we_min), .lim_wdata_i(wdata),
    .pix_i(pix), .pix_vld_i(vld), .pix_hs_i(hs), .pix_vs_i(vs),
    .pix_o(pix_o), .pix_vld_o(vld_o), .pix_hs_o(hs_o), .pix_vs_o(vs_o),
    .lim_max_o(lim_max_o), .lim_min_o(lim_min_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [23:0] m_hi, m_lo, e_pix;
  bit        m_prev, e_vld, e_hs, e_vs, e_full, live;

  function automatic bit [23:0] dflt_hi(input bit b);
    return b ? 24'hFEFEFE : 24'hF0EBF0;
  endfunction
  function automatic bit [23:0] dflt_lo(input bit b);
    return b ? 24'h010101 : 24'h101010;
  endfunction

  function automatic bit [23:0] ref_clip(input bit [23:0] p, input bit [23:0] lo,
                                         input bit [23:0] hi, input bit f);
    bit [23:0] r;
    r = '0;
    for (int k = 0; k < 3; k++) begin
      int c, l, h;
      c = (p >> (8*k)) & 255;
      l = (lo >> (8*k)) & 255;
      h = (hi >> (8*k)) & 255;
      if (!f) begin
        if (c < l) c = l;
        if (c > h) c = h;
      end
      r = r | (24'(c) << (8*k));
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hi = dflt_hi(byp); m_lo = dflt_lo(byp);
      e_pix = '0; e_vld = 0; e_hs = 0; e_vs = 0; e_full = 0;
      m_prev = byp; live = 1;
    end else begin
      e_pix = ref_clip(pix, m_lo, m_hi, full);
      e_vld = vld; e_hs = hs; e_vs = vs; e_full = full;
      if (byp != m_prev) begin
        m_hi = dflt_hi(byp); m_lo = dflt_lo(byp);
      end else begin
        if (we_max) m_hi = wdata;
        if (we_min) m_lo = wdata;
      end
      m_prev = byp;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(e_full ? "R5 model pixel" : "R3 model pixel", 32'(pix_o), 32'(e_pix));
      chk("R6 model sidebands", {29'd0, vld_o, hs_o, vs_o}, {29'd0, e_vld, e_hs, e_vs});
      chk("R2 model upper limits", 32'(lim_max_o), 32'(m_hi));
      chk("R2 model lower limits", 32'(lim_min_o), 32'(m_lo));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    we_max = 0; we_min = 0; full = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1 reset state, YCbCr defaults
    repeat (3) cyc();
    chk("R1 pixel in reset", 32'(pix_o), 32'h0);
    chk("R1 sidebands in reset", {29'd0, vld_o, hs_o, vs_o}, 32'h0);
    chk("R1 YCbCr upper default", 32'(lim_max_o), 32'hF0EBF0);
    chk("R1 YCbCr lower default", 32'(lim_min_o), 32'h101010);
    rst = 0;

    // R3 clipping with video levels, R6 sideband alignment
    pix = 24'h05FF80; vld = 1; hs = 0; vs = 1;
    cyc();
    chk("R3 clip low/high/pass", 32'(pix_o), 32'h10EB80);
    chk("R6 sidebands follow", {29'd0, vld_o, hs_o, vs_o}, 32'h5);
    pix = 24'h2080F5; vld = 0; hs = 1; vs = 0;
    cyc();
    chk("R3 chroma ceiling", 32'(pix_o), 32'h2080F0);
    chk("R6 pixel registered without valid", {29'd0, vld_o, hs_o, vs_o}, 32'h2);

    // R5 full range
    full = 1; pix = 24'h05FF80;
    cyc();
    chk("R5 pass-through", 32'(pix_o), 32'h05FF80);
    full = 0;

    // R2 programmed limits
    we_max = 1; wdata = 24'hC0D0E0;
    cyc();
    we_max = 0; we_min = 1; wdata = 24'h203040;
    cyc();
    chk("R2 upper write", 32'(lim_max_o), 32'hC0D0E0);
    we_min = 0; pix = 24'hFF0030;
    cyc();
    chk("R2 lower write", 32'(lim_min_o), 32'h203040);
    cyc();
    chk("R2 new limits applied", 32'(pix_o), 32'hC03040);

    // R4 inverted window
    we_max = 1; wdata = 24'h404040;
    cyc();
    we_max = 0; we_min = 1; wdata = 24'h808080;
    cyc();
    we_min = 0; pix = 24'h00FF50;
    cyc();
    pix = 24'h606060;
    cyc();
    chk("R4 upper bound wins", 32'(pix_o), 32'h404040);
    cyc();
    chk("R4 upper bound wins mid", 32'(pix_o), 32'h404040);

    // R7 mode change overrides colliding write
    byp = 1; we_max = 1; wdata = 24'h111111;
    cyc();
    we_max = 0;
    chk("R7 RGB upper reload", 32'(lim_max_o), 32'hFEFEFE);
    chk("R7 RGB lower reload", 32'(lim_min_o), 32'h010101);
    pix = 24'h00FFFF;
    cyc();
    cyc();
    chk("R7 RGB limits applied", 32'(pix_o), 32'h01FEFE);
    byp = 0;
    cyc();
    cyc();
    chk("R7 YCbCr reload", 32'(lim_max_o), 32'hF0EBF0);

    // R1 reset with RGB mode
    byp = 1; rst = 1;
    cyc();
    cyc();
    chk("R1 RGB upper default", 32'(lim_max_o), 32'hFEFEFE);
    chk("R1 RGB lower default", 32'(lim_min_o), 32'h010101);
    rst = 0;

    // random traffic against the model (R3, R5, R6, R2, R7)
    for (int i = 0; i < 3000; i++) begin
      cyc();
      quiet();
      pix = 24'($urandom);
      {vld, hs, vs} = 3'($urandom);
      full = ($urandom % 8) == 0;
      wdata = 24'($urandom);
      if (($urandom % 12) == 0) we_max = 1;
      if (($urandom % 12) == 0) we_min = 1;
      if (($urandom % 60) == 0) byp = ~byp;
    end
    cyc();
    quiet();
    cyc();
    finish_run();
  end

endmodule